// File: doc/BRIEF.md
# Microprogram Sequencer with Control Address Register

This block is the sequence-control half of a multi-cycle microprogrammed processor. It owns the control address register, a 17-bit register that addresses a control store of 42-bit microwords. On every clock edge it decides the address of the next microword. It either steps to the current address plus one or jumps to a loaded address.

A condition selector picks one of eight sources: two constants, four status flags and two inverted flags. When the selected condition is true, the register loads. Otherwise it increments. A second selector chooses where a loaded address comes from. It is either the microword's own next-address field, for jumps inside the microprogram, or the opcode of the instruction register zero-extended, for dispatch to the routine of an instruction. The microword's instruction-load, PC-increment and PC-load strobes pass straight through to the datapath.

Top module: `micro_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `car_o` becomes 0 at that edge; the reset is synchronous.
- R2: `cond_sel_i` chooses the condition as follows: 0 gives constant 0, 1 gives constant 1, 2 gives `flag_c_i`, 3 gives `flag_v_i`, 4 gives `flag_z_i`, 5 gives `flag_n_i`, 6 gives the inverse of `flag_c_i`, and 7 gives the inverse of `flag_z_i`.
- R3: When the selected condition is 0 and reset is inactive, `car_o` becomes its previous value plus one at the next edge.
- R4: When the selected condition is 1 and reset is inactive, `car_o` takes the load address at the next edge.
- R5: With `map_sel_i` = 0, the load address is `next_addr_i`.
- R6: With `map_sel_i` = 1, the load address is `opcode_i` placed in bits 6:0, with bits 16:7 zero.
- R7: Incrementing from 17'h1FFFF gives 0.
- R8: `ir_load_o`, `pc_inc_o` and `pc_load_o` equal `ir_load_i`, `pc_inc_i` and `pc_load_i` in the same cycle, with no register in between.
- R9: Reset takes priority over a load: with `rst_n` low and a true condition, `car_o` still becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| next_addr_i | input | 17 | Next-address field of the current microword |
| cond_sel_i | input | 3 | Condition select field of the current microword |
| map_sel_i | input | 1 | Load source select: 0 next-address field, 1 opcode |
| ir_load_i | input | 1 | Instruction-load strobe from the microword |
| pc_inc_i | input | 1 | PC-increment strobe from the microword |
| pc_load_i | input | 1 | PC-load strobe from the microword |
| opcode_i | input | 7 | Opcode field of the instruction register |
| flag_c_i | input | 1 | Carry status flag |
| flag_v_i | input | 1 | Overflow status flag |
| flag_z_i | input | 1 | Zero status flag |
| flag_n_i | input | 1 | Negative status flag |
| car_o | output | 17 | Current control address |
| ir_load_o | output | 1 | Instruction-load strobe to the datapath |
| pc_inc_o | output | 1 | PC-increment strobe to the datapath |
| pc_load_o | output | 1 | PC-load strobe to the datapath |

## Verification
The assertions assume that every microword field, flag and opcode is a known 0 or 1 at each rising edge while reset is inactive. They also assume that reset is driven low from time zero, so that no property looks at a register before its first reset. The stimulus changes inputs only on the falling edge, always drives defined values, and holds reset low through the first cycles. Directed sequences then sweep all eight condition selections against both polarities of each flag, force the register to its top value to exercise the wrap, and assert reset together with a true condition. A random phase mixes all fields while a behavioural model predicts the address.

// File: rtl/seq_pkg.sv
// Package: shared widths and the condition-select encoding for the
// microprogram sequencer. Assumes a 17-bit control address and a
// 7-bit opcode, zero-extended when used as a dispatch address.
package seq_pkg;
    localparam int CAR_W  = 17;
    localparam int OPC_W  = 7;
    localparam int SEL_W  = 3;
    localparam int N_COND = 1 << SEL_W;

    typedef enum logic [SEL_W-1:0] {
        COND_FALSE = 3'd0,
        COND_TRUE  = 3'd1,
        COND_C     = 3'd2,
        COND_V     = 3'd3,
        COND_Z     = 3'd4,
        COND_N     = 3'd5,
        COND_NC    = 3'd6,
        COND_NZ    = 3'd7
    } cond_sel_e;
endpackage

// File: rtl/seq_cond_mux.sv
// Condition selector: builds the eight candidate conditions (two
// constants, four flags, two inverted flags) and returns the one
// named by the select field. Purely combinational.
module seq_cond_mux
    import seq_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic [SW-1:0] sel_i,
    input  logic          c_i,
    input  logic          v_i,
    input  logic          z_i,
    input  logic          n_i,
    output logic          cond_o
);
    localparam int NC = 1 << SW;

    logic [NC-1:0] cand;

    // Gather candidate conditions in select order.
    always_comb begin
        cand           = '0;
        cand[COND_FALSE] = 1'b0;
        cand[COND_TRUE]  = 1'b1;
        cand[COND_C]     = c_i;
        cand[COND_V]     = v_i;
        cand[COND_Z]     = z_i;
        cand[COND_N]     = n_i;
        cand[COND_NC]    = ~c_i;
        cand[COND_NZ]    = ~z_i;
    end

    // Pick the selected condition.
    always_comb cond_o = cand[sel_i];
endmodule

// File: rtl/seq_addr_sel.sv
// Load-address selector: returns either the microword next-address
// field or the opcode zero-extended to the control address width.
// Assumes OW <= AW.
module seq_addr_sel #(
    parameter int AW = 17,
    parameter int OW = 7
) (
    input  logic          map_sel_i,
    input  logic [AW-1:0] next_addr_i,
    input  logic [OW-1:0] opcode_i,
    output logic [AW-1:0] load_addr_o
);
    localparam int PAD = AW - OW;

    logic [AW-1:0] mapped;

    // Zero-fill the opcode into the low bits.
    generate
        if (PAD > 0) begin : g_pad
            always_comb mapped = {{PAD{1'b0}}, opcode_i};
        end else begin : g_nopad
            always_comb mapped = opcode_i[AW-1:0];
        end
    endgenerate

    // Choose the load source.
    always_comb load_addr_o = map_sel_i ? mapped : next_addr_i;
endmodule

// File: rtl/seq_car_reg.sv
// Control address register: synchronous active-low reset to zero,
// otherwise loads the given address or increments with wrap-around.
module seq_car_reg #(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_addr_i,
    output logic [AW-1:0] car_o
);
    localparam logic [AW-1:0] START = '0;
    localparam logic [AW-1:0] STEP  = AW'(1);

    // Update the control address each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       car_o <= START;
        else if (load_i)  car_o <= load_addr_i;
        else              car_o <= car_o + STEP;
    end
endmodule

// File: rtl/micro_sequencer.sv
// Microprogram sequencer top: a condition selector decides between
// stepping and loading the control address register; an address
// selector supplies the load value. Microword strobes for the
// datapath pass through unchanged. Assumes inputs are stable and
// known around the rising edge and reset is low at start-up.
module micro_sequencer
    import seq_pkg::*;
#(
    parameter int AW = CAR_W,
    parameter int OW = OPC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] next_addr_i,
    input  logic [2:0]    cond_sel_i,
    input  logic          map_sel_i,
    input  logic          ir_load_i,
    input  logic          pc_inc_i,
    input  logic          pc_load_i,
    input  logic [OW-1:0] opcode_i,
    input  logic          flag_c_i,
    input  logic          flag_v_i,
    input  logic          flag_z_i,
    input  logic          flag_n_i,
    output logic [AW-1:0] car_o,
    output logic          ir_load_o,
    output logic          pc_inc_o,
    output logic          pc_load_o
);
    logic          take_load;
    logic [AW-1:0] load_addr;

    seq_cond_mux #(.SW(3)) u_cond (
        .sel_i  (cond_sel_i),
        .c_i    (flag_c_i),
        .v_i    (flag_v_i),
        .z_i    (flag_z_i),
        .n_i    (flag_n_i),
        .cond_o (take_load)
    );

    seq_addr_sel #(.AW(AW), .OW(OW)) u_addr (
        .map_sel_i   (map_sel_i),
        .next_addr_i (next_addr_i),
        .opcode_i    (opcode_i),
        .load_addr_o (load_addr)
    );

    seq_car_reg #(.AW(AW)) u_car (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (take_load),
        .load_addr_i (load_addr),
        .car_o       (car_o)
    );

    // Forward microword strobes to the datapath.
    always_comb begin
        ir_load_o = ir_load_i;
        pc_inc_o  = pc_inc_i;
        pc_load_o = pc_load_i;
    end

    AST_STEP_ON_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
        !take_load |=> car_o == AW'($past(car_o) + 1'b1)); // R3
    AST_LOAD_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        take_load && !map_sel_i |=> car_o == $past(next_addr_i)); // R5
    AST_LOAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        take_load && map_sel_i |=> car_o == AW'($past(opcode_i))); // R6
    AST_CONST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cond_sel_i == 3'd0 |=> car_o == AW'($past(car_o) + 1'b1)); // R2
    AST_CONST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        cond_sel_i == 3'd1 && !map_sel_i |=> car_o == $past(next_addr_i)); // R4
endmodule

// File: tb/micro_sequencer_test.sv
module micro_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] next_addr = '0;
    logic [2:0]  sel = '0;
    logic        mc = 1'b0;
    logic        il = 1'b0, pi = 1'b0, pl = 1'b0;
    logic [6:0]  opc = '0;
    logic        fc = 1'b0, fv = 1'b0, fz = 1'b0, fn = 1'b0;
    logic [16:0] car;
    logic        il_o, pi_o, pl_o;

    int checks = 0;
    int fails = 0;
    int exp_car = 0;
    string exp_tag = "R1";

    always #2.5 clk = ~clk;

    micro_sequencer uut (
        .clk(clk), .rst_n(rst_n), .next_addr_i(next_addr), .cond_sel_i(sel),
        .map_sel_i(mc), .ir_load_i(il), .pc_inc_i(pi), .pc_load_i(pl),
        .opcode_i(opc), .flag_c_i(fc), .flag_v_i(fv), .flag_z_i(fz),
        .flag_n_i(fn), .car_o(car), .ir_load_o(il_o), .pc_inc_o(pi_o),
        .pc_load_o(pl_o)
    );

    function automatic bit ref_cond(int s, bit c, bit v, bit z, bit n);
        case (s)
            0: return 1'b0;
            1: return 1'b1;
            2: return c;
            3: return v;
            4: return z;
            5: return n;
            6: return !c;
            default: return !z;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: check last prediction, drive, predict next address.
    task automatic step(bit r, int s, bit m, int na, int op,
                        bit c, bit v, bit z, bit n, bit a, bit b, bit d);
        bit cond;
        @(negedge clk);
        check(exp_tag, int'(car), exp_car);
        rst_n = r; sel = 3'(s); mc = m; next_addr = 17'(na); opc = 7'(op);
        fc = c; fv = v; fz = z; fn = n; il = a; pi = b; pl = d;
        #1;
        check("R8", int'({il_o, pi_o, pl_o}), int'({a, b, d}));
        cond = ref_cond(s, c, v, z, n);
        if (!r) begin
            exp_car = 0;
            exp_tag = cond ? "R9" : "R1";
        end else if (cond) begin
            exp_car = m ? (op & 32'h7f) : (na & 32'h1ffff);
            exp_tag = (s >= 2) ? (m ? "R2/R4/R6" : "R2/R4/R5")
                               : (m ? "R4/R6" : "R4/R5");
        end else begin
            exp_tag = (exp_car == 32'h1ffff) ? "R7" : ((s >= 2 || s == 0) ? "R2/R3" : "R3");
            exp_car = (exp_car + 1) & 32'h1ffff;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stim
        // R1: reset held
        repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R3: plain stepping
        repeat (4) step(1, 0, 0, 17'h155, 0, 1, 1, 1, 1, 1, 0, 1);
        // R5 / R6: both load sources with constant true
        step(1, 1, 0, 17'h1abcd, 7'h55, 0, 0, 0, 0, 0, 1, 0);
        step(1, 1, 1, 17'h1abcd, 7'h55, 0, 0, 0, 0, 1, 1, 1);
        step(1, 0, 1, 17'h00001, 7'h7f, 0, 0, 0, 0, 0, 0, 0);
        // R2: every select against both flag polarities
        for (int s = 0; s < 8; s++) begin
            for (int f = 0; f < 2; f++) begin
                step(1, s, 0, 17'h100 + s * 16 + f, 0, f[0], f[0], f[0], f[0], 0, 0, 0);
                step(1, s, 0, 17'h200 + s, 0, !f[0], f[0], !f[0], f[0], 0, 0, 0);
            end
        end
        // R7: wrap from the top address
        step(1, 1, 0, 17'h1ffff, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R9: reset beats a true condition
        step(1, 1, 0, 17'h0abc, 0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 1, 0, 17'h1234, 0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 2, 1, 17'h1234, 7'h11, 1, 0, 0, 0, 0, 0, 0);
        // Random mix
        for (int i = 0; i < 400; i++) begin
            int rv = int'($urandom);
            step(($urandom % 20) != 0, int'($urandom % 8), rv[0], int'($urandom),
                 int'($urandom), rv[1], rv[2], rv[3], rv[4], rv[5], rv[6], rv[7]);
        end
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule